// File: doc/BRIEF.md
# Asymmetric Dual-Issue Pairing Unit

This block is the issue stage of a processor core that has two unlike pipes. One is an integer-side pipe with five stages. It takes ALU work, branches and every memory access, including loads and stores of floating-point registers. The other is a seven-stage floating-point computation pipe. It takes adds, subtracts, fused multiply-adds and format conversions. In each cycle the fetch buffer presents its two oldest pre-decoded instructions. Slot 0 holds the older one and slot 1 the younger one. Each slot carries a valid bit, a class bit, a destination register and up to two source registers. Each pipe also supplies a ready flag.

The unit issues the older instruction alone, issues both instructions, or issues nothing. It never breaks program order, never sends two instructions to the same pipe, and never pairs two instructions when the younger one depends on a register the older one writes. The decision is held in an issue register. In the cycle after the slots are sampled, the unit presents one strobe per pipe, a flag per pipe telling whether that pipe received the younger slot, and a count of consumed slots. The fetch buffer uses that count to shift.

A register specifier is 6 bits wide. Bit 5 selects the file: 0 means integer and 1 means floating-point. Bits 4:0 give the index. Integer register 0 is hard-wired to zero, so a write to it never creates a dependence.

Top module: `dual_issue_pair`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output is 0 after that edge, whatever the slot inputs are.
- R2: The outputs change only at a rising clock edge. They reflect the inputs that were sampled at that edge.
- R3: The older slot issues when it is valid and the ready flag of its own pipe is high. Class 0 goes to the integer pipe (`int_issue`) and class 1 goes to the floating-point pipe (`fp_issue`).
- R4: The younger slot never issues in a cycle in which the older slot does not issue.
- R5: Two valid slots of the same class never issue together. Only the older one can issue.
- R6: If the younger slot has an enabled source equal to the older slot's enabled destination, the younger slot does not issue. A destination of 6'h00 (integer register 0) is exempt. Registers with the same index in different files do not match.
- R7: If both slots have enabled destinations that are equal and not 6'h00, the younger slot does not issue.
- R8: If the younger slot's pipe is not ready, the younger slot does not issue. The older slot is unaffected.
- R9: `consumed` equals the number of strobes that are high, from 0 to 2. Each pipe receives at most one instruction.
- R10: `int_from_s1` or `fp_from_s1` is 1 exactly when that pipe's strobe carries the younger slot. Otherwise the strobe carries the older slot.
- R11: An invalid older slot means that nothing issues, even when the younger slot is valid and ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s0_valid | input | 1 | Older slot holds an instruction |
| s0_cls | input | 1 | Older slot class: 0 integer-side, 1 FP computation |
| s0_dst_en | input | 1 | Older slot writes a register |
| s0_dst | input | 6 | Older slot destination specifier |
| s0_sa_en | input | 1 | Older slot source A used |
| s0_sa | input | 6 | Older slot source A specifier |
| s0_sb_en | input | 1 | Older slot source B used |
| s0_sb | input | 6 | Older slot source B specifier |
| s1_valid | input | 1 | Younger slot holds an instruction |
| s1_cls | input | 1 | Younger slot class |
| s1_dst_en | input | 1 | Younger slot writes a register |
| s1_dst | input | 6 | Younger slot destination specifier |
| s1_sa_en | input | 1 | Younger slot source A used |
| s1_sa | input | 6 | Younger slot source A specifier |
| s1_sb_en | input | 1 | Younger slot source B used |
| s1_sb | input | 6 | Younger slot source B specifier |
| int_rdy | input | 1 | Integer pipe can accept an instruction |
| fp_rdy | input | 1 | FP computation pipe can accept an instruction |
| int_issue | output | 1 | Instruction issued to the integer pipe |
| fp_issue | output | 1 | Instruction issued to the FP pipe |
| int_from_s1 | output | 1 | Integer strobe carries the younger slot |
| fp_from_s1 | output | 1 | FP strobe carries the younger slot |
| consumed | output | 2 | Slots the fetch buffer shifts out |

## Verification
The hardest case to reach is a pair that is blocked by one hazard alone. Both slots must be valid and of different classes, both pipes must be ready, and exactly one register specifier must coincide. The integer zero register and same-index registers in the two files must sit at the edge of that match. Random slots almost never line up this way. Directed cases therefore build each of these collisions deliberately. After that, a long random phase draws register indices from a very small range, so that matches, the zero-register exemption and cross-file near-misses occur often next to changing ready flags.

// File: rtl/pair_pkg.sv
package pair_pkg;

    parameter int REG_IDX_W = 5;
    localparam int SPEC_W   = REG_IDX_W + 1;
    localparam int NUM_SRC  = 2;
    localparam int CNT_W    = 2;

    typedef enum logic {
        CLS_INT = 1'b0,
        CLS_FPC = 1'b1
    } iclass_e;

    typedef struct packed {
        logic                 fpfile;
        logic [REG_IDX_W-1:0] idx;
    } rspec_t;

    typedef struct packed {
        logic    valid;
        iclass_e cls;
        logic    dst_en;
        rspec_t  dst;
        logic    sa_en;
        rspec_t  sa;
        logic    sb_en;
        rspec_t  sb;
    } slot_t;

    typedef struct packed {
        logic             int_go;
        logic             fp_go;
        logic             int_young;
        logic             fp_young;
        logic [CNT_W-1:0] used;
    } issue_t;

    // A write that can create a dependence (integer register 0 never does).
    function automatic logic real_write(input slot_t s);
        return s.dst_en && !(!s.dst.fpfile && s.dst.idx == '0);
    endfunction

    function automatic logic pipe_ready(input iclass_e c, input logic irdy, input logic frdy);
        return (c == CLS_FPC) ? frdy : irdy;
    endfunction

endpackage

// File: rtl/pair_hazard.sv
module pair_hazard
    import pair_pkg::*;
(
    input  slot_t older,
    input  slot_t younger,
    output logic  conflict
);
    rspec_t ysrc    [NUM_SRC];
    logic   ysrc_en [NUM_SRC];
    logic   raw_hit [NUM_SRC];
    logic   waw_hit;
    logic   wr_old;

    always_comb begin
        ysrc[0]    = younger.sa;
        ysrc_en[0] = younger.sa_en;
        ysrc[1]    = younger.sb;
        ysrc_en[1] = younger.sb_en;
    end

    assign wr_old = real_write(older);

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        assign raw_hit[k] = wr_old && ysrc_en[k] && (ysrc[k] == older.dst);
    end

    assign waw_hit = wr_old && younger.dst_en && (younger.dst == older.dst);

    always_comb begin
        conflict = waw_hit;
        for (int k = 0; k < NUM_SRC; k++) begin
            conflict = conflict | raw_hit[k];
        end
    end
endmodule

// File: rtl/pair_select.sv
module pair_select
    import pair_pkg::*;
(
    input  slot_t  older,
    input  slot_t  younger,
    input  logic   int_rdy,
    input  logic   fp_rdy,
    input  logic   conflict,
    output issue_t dec
);
    logic old_go;
    logic young_go;

    assign old_go   = older.valid && pipe_ready(older.cls, int_rdy, fp_rdy);
    assign young_go = old_go && younger.valid && (younger.cls != older.cls)
                      && pipe_ready(younger.cls, int_rdy, fp_rdy) && !conflict;

    always_comb begin
        dec           = '0;
        dec.int_young = young_go && (younger.cls == CLS_INT);
        dec.fp_young  = young_go && (younger.cls == CLS_FPC);
        dec.int_go    = (old_go && older.cls == CLS_INT) || dec.int_young;
        dec.fp_go     = (old_go && older.cls == CLS_FPC) || dec.fp_young;
        dec.used      = CNT_W'(old_go) + CNT_W'(young_go);
    end
endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
    import pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              s0_valid,
    input  logic              s0_cls,
    input  logic              s0_dst_en,
    input  logic [SPEC_W-1:0] s0_dst,
    input  logic              s0_sa_en,
    input  logic [SPEC_W-1:0] s0_sa,
    input  logic              s0_sb_en,
    input  logic [SPEC_W-1:0] s0_sb,
    input  logic              s1_valid,
    input  logic              s1_cls,
    input  logic              s1_dst_en,
    input  logic [SPEC_W-1:0] s1_dst,
    input  logic              s1_sa_en,
    input  logic [SPEC_W-1:0] s1_sa,
    input  logic              s1_sb_en,
    input  logic [SPEC_W-1:0] s1_sb,
    input  logic              int_rdy,
    input  logic              fp_rdy,
    output logic              int_issue,
    output logic              fp_issue,
    output logic              int_from_s1,
    output logic              fp_from_s1,
    output logic [CNT_W-1:0]  consumed
);
    slot_t  older;
    slot_t  younger;
    logic   conflict;
    issue_t dec;
    issue_t dec_q;

    always_comb begin
        older  = '{valid: s0_valid, cls: iclass_e'(s0_cls), dst_en: s0_dst_en, dst: s0_dst,
                   sa_en: s0_sa_en, sa: s0_sa, sb_en: s0_sb_en, sb: s0_sb};
        younger = '{valid: s1_valid, cls: iclass_e'(s1_cls), dst_en: s1_dst_en, dst: s1_dst,
                    sa_en: s1_sa_en, sa: s1_sa, sb_en: s1_sb_en, sb: s1_sb};
    end

    pair_hazard u_hazard (
        .older    (older),
        .younger  (younger),
        .conflict (conflict)
    );

    pair_select u_select (
        .older    (older),
        .younger  (younger),
        .int_rdy  (int_rdy),
        .fp_rdy   (fp_rdy),
        .conflict (conflict),
        .dec      (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec;
        end
    end

    assign int_issue   = dec_q.int_go;
    assign fp_issue    = dec_q.fp_go;
    assign int_from_s1 = dec_q.int_young;
    assign fp_from_s1  = dec_q.fp_young;
    assign consumed    = dec_q.used;
endmodule

// File: rtl/dual_issue_pair_chk.sv
module dual_issue_pair_chk
    import pair_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              s0_valid,
    input logic              s0_cls,
    input logic              s0_dst_en,
    input logic [SPEC_W-1:0] s0_dst,
    input logic              s1_valid,
    input logic              s1_cls,
    input logic              s1_sa_en,
    input logic [SPEC_W-1:0] s1_sa,
    input logic              int_issue,
    input logic              fp_issue,
    input logic              int_from_s1,
    input logic              fp_from_s1,
    input logic [CNT_W-1:0]  consumed
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!int_issue && !fp_issue && consumed == '0));

    a_r4_order_kept: assert property (@(posedge clk) disable iff (rst)
        (int_from_s1 || fp_from_s1) |-> (int_issue && fp_issue && !(int_from_s1 && fp_from_s1)));

    a_r9_count_matches: assert property (@(posedge clk) disable iff (rst)
        consumed == CNT_W'($countones({int_issue, fp_issue})));

    a_r5_same_class_single: assert property (@(posedge clk) disable iff (rst)
        (s0_valid && s1_valid && s0_cls == s1_cls) |=> (consumed != 2'd2));

    a_r6_raw_blocks: assert property (@(posedge clk) disable iff (rst)
        (s0_dst_en && s0_dst != '0 && s1_sa_en && s1_sa == s0_dst) |=> (consumed != 2'd2));

    a_r11_no_older_nothing: assert property (@(posedge clk) disable iff (rst)
        !s0_valid |=> (consumed == '0));
endmodule

bind dual_issue_pair dual_issue_pair_chk chk_i (.*);

// File: tb/dual_issue_pair_tb_top.sv
module dual_issue_pair_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic       s0_valid, s0_cls, s0_dst_en, s0_sa_en, s0_sb_en;
    logic [5:0] s0_dst, s0_sa, s0_sb;
    logic       s1_valid, s1_cls, s1_dst_en, s1_sa_en, s1_sb_en;
    logic [5:0] s1_dst, s1_sa, s1_sb;
    logic       int_rdy, fp_rdy;
    logic       int_issue, fp_issue, int_from_s1, fp_from_s1;
    logic [1:0] consumed;

    int checks = 0;
    int fails  = 0;
    logic [5:0] pend;   // {int, fp, int_s1, fp_s1, consumed[1:0]}
    logic [5:0] prev;

    always #4 clk = ~clk;

    dual_issue_pair dut_i (.*);

    function automatic logic [5:0] model();
        logic ii, fi, is1, fs1;
        int n;
        bit dep;
        logic [5:0] srcs[2];
        logic       sens[2];
        ii = 0; fi = 0; is1 = 0; fs1 = 0; n = 0;
        if (rst) return 6'b0;
        if (!s0_valid) return 6'b0;
        if (s0_cls ? !fp_rdy : !int_rdy) return 6'b0;
        if (s0_cls) fi = 1; else ii = 1;
        n = 1;
        dep = 0;
        srcs[0] = s1_sa; sens[0] = s1_sa_en;
        srcs[1] = s1_sb; sens[1] = s1_sb_en;
        if (s0_dst_en && s0_dst != 6'h00) begin
            foreach (srcs[i]) if (sens[i] && srcs[i] == s0_dst) dep = 1;
            if (s1_dst_en && s1_dst == s0_dst) dep = 1;
        end
        if (s1_valid && s1_cls != s0_cls && (s1_cls ? fp_rdy : int_rdy) && !dep) begin
            n = 2;
            if (s1_cls) begin fi = 1; fs1 = 1; end
            else begin ii = 1; is1 = 1; end
        end
        return {ii, fi, is1, fs1, 2'(n)};
    endfunction

    function automatic logic [5:0] seen();
        return {int_issue, fp_issue, int_from_s1, fp_from_s1, consumed};
    endfunction

    task automatic check(input string tag, input logic [5:0] exp);
        checks++;
        if (seen() !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, seen(), exp);
        end
    endtask

    task automatic slot0(input bit v, input bit c, input bit de, input logic [5:0] d,
                         input bit ae, input logic [5:0] a, input bit be, input logic [5:0] b);
        s0_valid = v; s0_cls = c; s0_dst_en = de; s0_dst = d;
        s0_sa_en = ae; s0_sa = a; s0_sb_en = be; s0_sb = b;
    endtask

    task automatic slot1(input bit v, input bit c, input bit de, input logic [5:0] d,
                         input bit ae, input logic [5:0] a, input bit be, input logic [5:0] b);
        s1_valid = v; s1_cls = c; s1_dst_en = de; s1_dst = d;
        s1_sa_en = ae; s1_sa = a; s1_sb_en = be; s1_sb = b;
    endtask

    // Inputs are already set; capture model, clock once, compare 2 ns later.
    task automatic step(input string tag);
        pend = model();
        @(posedge clk);
        #2;
        check(tag, pend);
        prev = pend;
    endtask

    task automatic step_expect(input string tag, input logic [5:0] exp);
        pend = model();
        @(posedge clk);
        #2;
        check(tag, exp);
        check({tag, " model"}, pend);
        prev = pend;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: got hang expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int_rdy = 1; fp_rdy = 1;
        slot0(1, 0, 1, 6'h01, 0, 0, 0, 0);
        slot1(1, 1, 1, 6'h22, 0, 0, 0, 0);
        @(posedge clk);
        #2;
        // R1: reset held while a pairable pair is presented
        step_expect("R1", 6'b000000);
        step_expect("R1", 6'b000000);
        rst = 0;

        // R10: integer older, FP younger pairs
        step_expect("R10", 6'b110110);
        // R2: new inputs leave outputs unchanged until the next edge
        slot0(1, 0, 1, 6'h01, 0, 0, 0, 0);
        slot1(0, 0, 0, 0, 0, 0, 0, 0);
        #1;
        check("R2", prev);
        #1;
        // R3: lone integer
        step_expect("R3", 6'b100001);
        // R3: lone FP
        slot0(1, 1, 1, 6'h21, 1, 6'h22, 0, 0);
        step_expect("R3", 6'b010001);
        // R10: FP older, integer younger
        slot1(1, 0, 1, 6'h03, 1, 6'h04, 0, 0);
        step_expect("R10", 6'b111010);
        // R5: two integer-side
        slot0(1, 0, 1, 6'h05, 0, 0, 0, 0);
        slot1(1, 0, 1, 6'h06, 0, 0, 0, 0);
        step_expect("R5", 6'b100001);
        // R5: two FP
        slot0(1, 1, 1, 6'h25, 0, 0, 0, 0);
        slot1(1, 1, 1, 6'h26, 0, 0, 0, 0);
        step_expect("R5", 6'b010001);
        // R6: RAW via source A (FP store of f3 after FP add writes f3)
        slot0(1, 1, 1, 6'h23, 0, 0, 0, 0);
        slot1(1, 0, 0, 0, 1, 6'h23, 1, 6'h02);
        step_expect("R6", 6'b010001);
        // R6: RAW via source B
        slot1(1, 0, 0, 0, 1, 6'h02, 1, 6'h23);
        step_expect("R6", 6'b010001);
        // R6: write to integer register 0 is exempt
        slot0(1, 0, 1, 6'h00, 0, 0, 0, 0);
        slot1(1, 1, 1, 6'h21, 1, 6'h00, 0, 0);
        step_expect("R6", 6'b110101 & 6'b110110 | 6'b000010);
        // R6: same index, different file, no match
        slot0(1, 0, 1, 6'h05, 0, 0, 0, 0);
        slot1(1, 1, 1, 6'h21, 1, 6'h25, 0, 0);
        step_expect("R6", 6'b110110);
        // R7: WAW on f2
        slot0(1, 1, 1, 6'h22, 0, 0, 0, 0);
        slot1(1, 0, 1, 6'h22, 1, 6'h01, 0, 0);
        step_expect("R7", 6'b010001);
        // R8: younger FP pipe not ready
        slot0(1, 0, 1, 6'h07, 0, 0, 0, 0);
        slot1(1, 1, 1, 6'h27, 0, 0, 0, 0);
        fp_rdy = 0;
        step_expect("R8", 6'b100001);
        // R4: older blocked, younger would be ready
        fp_rdy = 1; int_rdy = 0;
        step_expect("R4", 6'b000000);
        int_rdy = 1;
        // R11: invalid older
        slot0(0, 0, 0, 0, 0, 0, 0, 0);
        step_expect("R11", 6'b000000);

        // R9: random mix with a small register space
        for (int i = 0; i < 3000; i++) begin
            slot0($urandom_range(0, 7) != 0, 1'($urandom), 1'($urandom), {1'($urandom), 5'($urandom_range(0, 2))},
                  1'($urandom), {1'($urandom), 5'($urandom_range(0, 2))},
                  1'($urandom), {1'($urandom), 5'($urandom_range(0, 2))});
            slot1($urandom_range(0, 7) != 0, 1'($urandom), 1'($urandom), {1'($urandom), 5'($urandom_range(0, 2))},
                  1'($urandom), {1'($urandom), 5'($urandom_range(0, 2))},
                  1'($urandom), {1'($urandom), 5'($urandom_range(0, 2))});
            int_rdy = $urandom_range(0, 4) != 0;
            fp_rdy  = $urandom_range(0, 4) != 0;
            step("R9");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule